// File: doc/BRIEF.md
# RTC-Style Interrupt Event Generator

The block turns a timer comparator into the three interrupt sources of a classic real-time clock. It watches an external free-running counter and keeps its own comparator value. Each time the counter reaches the comparator, the block services the event. It steps the comparator forward by one base period (64 Hz by default) until the comparator is ahead of the counter again. It then decides which of three events to report. An update event means the seconds value changed since the last service. An alarm event means the current time equals a stored hh:mm:ss. A periodic event fires on every Nth service, or on every service when a rate faster than the base rate has been requested.

Software-side control arrives as single-cycle strobes. These set or clear individual event enables, load the alarm time, and load a periodic rate code k (meaning 2^k Hz). Results leave as a 16-bit status word and a one-clock interrupt strobe. The current comparator value and the channel-enabled state are outputs as well, so that they can drive the timer hardware.

The counter runs at 2^LOG2_TPS ticks per second (default 65536). The default step is therefore 2^(LOG2_TPS-BASE_LOG2) = 1024 ticks.

Top module: `rtc_evt_gen`

## Requirements
- R1: After reset, `irq` is 0, `status` is 0, `chan_on` is 0 and `cmp_val` is 0.
- R2: The enable bits are update = bit 0, alarm = bit 1 and periodic = bit 2 of `en_set`/`en_clr`. When set and clear hit the same bit in the same cycle, clear wins. `chan_on` is 1 exactly while at least one enable is held.
- R3: When the first enable arrives while all enables are off, `cmp_val` becomes `ctr_i` plus the active step on that clock edge.
- R4: While `chan_on` is 1 and the signed value `ctr_i - cmp_val` is 0 or more, a service starts. The comparator advances by one step per clock until the signed value `ctr_i - cmp_val` is no longer positive. `irq` is high for exactly one clock, on the edge after the last advance, and only if at least one flag is set.
- R5: When `irq` is high, the status word reads as follows: bit 7 is pending = 1, bit 6 is periodic, bit 5 is alarm, bit 4 is update, bits 3:0 are 0, and bits 15:8 hold 1.
- R6: After update goes from disabled to enabled, the first service that sees a new seconds value only records it and raises no update flag. Later services raise the update flag when the seconds value differs from the recorded one.
- R7: The alarm flag is raised on a service when alarm is enabled and the current hour, minute and second all equal the loaded alarm values.
- R8: A rate code k of BASE_LOG2 or less sets a divide limit of 2^(BASE_LOG2-k). Each service with periodic enabled adds 1 to the count. The periodic flag rises when the count reaches the limit, and the count then clears.
- R9: A rate code k above BASE_LOG2 selects a step of 2^(LOG2_TPS-k) while periodic is enabled. In that case every service raises the periodic flag.
- R10: Each comparator advance beyond the first in one service is a lost tick. When periodic is enabled, the lost ticks are added to the periodic count before the increment of that service.
- R11: With all enables off, the channel is off and no service or `irq` occurs, even when the counter passes the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctr_i | input | CW | Free-running main counter value |
| now_hr | input | 5 | Current hour |
| now_min | input | 6 | Current minute |
| now_sec | input | 6 | Current second |
| en_set | input | 3 | Enable set strobes (bit 0 update, 1 alarm, 2 periodic) |
| en_clr | input | 3 | Enable clear strobes, same bit order |
| alm_load | input | 1 | Load alarm time |
| alm_hr | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| per_load | input | 1 | Load periodic rate code |
| per_code | input | 4 | Rate code k, rate is 2^k Hz |
| status | output | 16 | Event status word |
| irq | output | 1 | One-clock interrupt strobe |
| chan_on | output | 1 | Timer channel enabled |
| cmp_val | output | CW | Current comparator value |

## Verification
Several properties are checked on every cycle, whatever the counter or time inputs do:
- the strobe never lasts two clocks;
- every strobe carries a well-formed status word;
- a strobe only follows a cycle in which the channel was on;
- a clear strobe always leaves its enable bit off;
- a service that sees an invalid previous second never yields an update flag.

The arithmetic needs the bench's scenarios to show it. This covers the comparator landing one step past a late counter, the lost-tick contribution to the periodic divider, the fast-rate step, and matching on all three alarm fields.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

  typedef enum logic [1:0] {
    CU_IDLE = 2'd0,
    CU_ADV  = 2'd1,
    CU_DONE = 2'd2
  } cu_state_e;

  localparam int unsigned EV_UPD = 0;
  localparam int unsigned EV_ALM = 1;
  localparam int unsigned EV_PER = 2;
  localparam int unsigned EV_N   = 3;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } tod_t;

  // divide limit for rate 2^code against base 2^base_log2; 0 = fast mode
  function automatic int unsigned rate_limit(int unsigned base_log2, int unsigned code);
    if (code > base_log2) return 0;
    return 32'd1 << (base_log2 - code);
  endfunction

  // counter ticks per period of rate 2^code at 2^tps_log2 ticks per second
  function automatic int unsigned rate_step(int unsigned tps_log2, int unsigned code);
    if (code >= tps_log2) return 1;
    return 32'd1 << (tps_log2 - code);
  endfunction

endpackage

// File: rtl/rtc_evt_cfg.sv
module rtc_evt_cfg
  import rtc_evt_pkg::*;
#(
  parameter int unsigned CW        = 32,
  parameter int unsigned PCW       = 16,
  parameter int unsigned LOG2_TPS  = 16,
  parameter int unsigned BASE_LOG2 = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EV_N-1:0] en_set_i,
  input  logic [EV_N-1:0] en_clr_i,
  input  logic           alm_load_i,
  input  tod_t           alm_tod_i,
  input  logic           per_load_i,
  input  logic [3:0]     per_code_i,
  output logic [EV_N-1:0] en_o,
  output logic           arm_o,
  output logic           uen_rise_o,
  output tod_t           alm_o,
  output logic [PCW-1:0] limit_o,
  output logic [CW-1:0]  step_o
);

  localparam logic [CW-1:0]  DEF_STEP  = CW'(rate_step(LOG2_TPS, BASE_LOG2));
  localparam logic [PCW-1:0] DEF_LIMIT = PCW'(1);

  logic [EV_N-1:0] en_q, en_nxt;
  logic            fast_q;
  logic [CW-1:0]   fast_step_q;
  logic [PCW-1:0]  limit_q;
  tod_t            alm_q;

  // clear has priority over set
  assign en_nxt     = (en_q | en_set_i) & ~en_clr_i;
  assign arm_o      = (en_q == '0) && (en_nxt != '0);
  assign uen_rise_o = !en_q[EV_UPD] && en_nxt[EV_UPD];
  assign step_o     = (fast_q && en_nxt[EV_PER]) ? fast_step_q : DEF_STEP;
  assign en_o       = en_q;
  assign alm_o      = alm_q;
  assign limit_o    = limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '0;
      fast_q      <= 1'b0;
      fast_step_q <= DEF_STEP;
      limit_q     <= DEF_LIMIT;
      alm_q       <= '0;
    end else begin
      en_q <= en_nxt;
      if (alm_load_i) alm_q <= alm_tod_i;
      if (per_load_i) begin
        limit_q     <= PCW'(rate_limit(BASE_LOG2, 32'(per_code_i)));
        fast_q      <= (32'(per_code_i) > BASE_LOG2);
        fast_step_q <= CW'(rate_step(LOG2_TPS, 32'(per_code_i)));
      end
    end
  end

  // R2
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr_i) |=> ((en_q & $past(en_clr_i)) == '0));

endmodule

// File: rtl/rtc_evt_catchup.sv
module rtc_evt_catchup
  import rtc_evt_pkg::*;
#(
  parameter int unsigned CW = 32,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctr_i,
  input  logic          chan_on_i,
  input  logic          arm_i,
  input  logic [CW-1:0] step_i,
  output logic [CW-1:0] cmp_o,
  output logic          done_o,
  output logic [LW-1:0] lost_o
);

  localparam logic [LW-1:0] LOST_MAX = '1;

  cu_state_e        state_q;
  logic [CW-1:0]    cmp_q, cmp_inc;
  logic [LW-1:0]    lost_q;
  logic signed [CW-1:0] diff_now, diff_inc;
  logic             hit_w, behind_w;

  assign cmp_inc  = cmp_q + step_i;
  assign diff_now = $signed(ctr_i - cmp_q);
  assign diff_inc = $signed(ctr_i - cmp_inc);
  assign hit_w    = (diff_now >= 0);
  assign behind_w = (diff_inc > 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CU_IDLE;
      cmp_q   <= '0;
      lost_q  <= '0;
    end else if (arm_i) begin
      cmp_q   <= ctr_i + step_i;
      lost_q  <= '0;
      state_q <= CU_IDLE;
    end else begin
      unique case (state_q)
        CU_IDLE: if (chan_on_i && hit_w) begin
          cmp_q   <= cmp_inc;
          lost_q  <= '0;
          state_q <= behind_w ? CU_ADV : CU_DONE;
        end
        CU_ADV: begin
          cmp_q   <= cmp_inc;
          lost_q  <= (lost_q == LOST_MAX) ? lost_q : lost_q + 1'b1;
          state_q <= behind_w ? CU_ADV : CU_DONE;
        end
        default: state_q <= CU_IDLE;
      endcase
    end
  end

  assign cmp_o  = cmp_q;
  assign done_o = (state_q == CU_DONE);
  assign lost_o = lost_q;

  // R11
  chan_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CU_IDLE && !chan_on_i && !arm_i) |=> (state_q == CU_IDLE));

endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
  import rtc_evt_pkg::*;
#(
  parameter int unsigned PCW = 16,
  parameter int unsigned LW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_i,
  input  logic [LW-1:0]   lost_i,
  input  logic [EV_N-1:0] en_i,
  input  logic            uen_rise_i,
  input  tod_t            now_i,
  input  tod_t            alm_i,
  input  logic [PCW-1:0]  limit_i,
  output logic [15:0]     status_o,
  output logic            irq_o
);

  logic [5:0]     prev_q;
  logic           prev_valid_q;
  logic [PCW-1:0] pcount_q, pc_sum, pc_inc;
  logic           sec_moved, uf_w, af_w, pf_w, any_w;
  logic [15:0]    status_q;
  logic           irq_q;

  assign sec_moved = !prev_valid_q || (now_i.sc != prev_q);
  assign uf_w      = en_i[EV_UPD] && sec_moved && prev_valid_q;
  assign af_w      = en_i[EV_ALM] && (now_i == alm_i);
  assign pc_sum    = pcount_q + (en_i[EV_PER] ? PCW'(lost_i) : '0);
  assign pc_inc    = pc_sum + 1'b1;
  assign pf_w      = en_i[EV_PER] && (pc_inc >= limit_i);
  assign any_w     = uf_w || af_w || pf_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q       <= '0;
      prev_valid_q <= 1'b0;
      pcount_q     <= '0;
      status_q     <= '0;
      irq_q        <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (done_i) begin
        if (en_i[EV_UPD] && sec_moved) begin
          prev_q       <= now_i.sc;
          prev_valid_q <= 1'b1;
        end
        if (en_i[EV_PER]) pcount_q <= pf_w ? '0 : pc_inc;
        if (any_w) begin
          status_q <= {8'd1, 1'b1, pf_w, af_w, uf_w, 4'b0000};
          irq_q    <= 1'b1;
        end
      end
      if (uen_rise_i) prev_valid_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R6
  first_upd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !prev_valid_q) |=> !(irq_q && status_q[4]));

endmodule

// File: rtl/rtc_evt_gen.sv
module rtc_evt_gen
  import rtc_evt_pkg::*;
#(
  parameter int unsigned CW        = 32,
  parameter int unsigned PCW       = 16,
  parameter int unsigned LW        = 8,
  parameter int unsigned LOG2_TPS  = 16,
  parameter int unsigned BASE_LOG2 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctr_i,
  input  logic [4:0]    now_hr,
  input  logic [5:0]    now_min,
  input  logic [5:0]    now_sec,
  input  logic [2:0]    en_set,
  input  logic [2:0]    en_clr,
  input  logic          alm_load,
  input  logic [4:0]    alm_hr,
  input  logic [5:0]    alm_min,
  input  logic [5:0]    alm_sec,
  input  logic          per_load,
  input  logic [3:0]    per_code,
  output logic [15:0]   status,
  output logic          irq,
  output logic          chan_on,
  output logic [CW-1:0] cmp_val
);

  logic [EV_N-1:0] en_w;
  logic            arm_w, uen_rise_w, done_w;
  tod_t            alm_w, now_w, alm_in_w;
  logic [PCW-1:0]  limit_w;
  logic [CW-1:0]   step_w;
  logic [LW-1:0]   lost_w;

  assign now_w    = '{hr: now_hr, mn: now_min, sc: now_sec};
  assign alm_in_w = '{hr: alm_hr, mn: alm_min, sc: alm_sec};
  assign chan_on  = |en_w;

  rtc_evt_cfg #(.CW(CW), .PCW(PCW), .LOG2_TPS(LOG2_TPS), .BASE_LOG2(BASE_LOG2)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_set_i(en_set), .en_clr_i(en_clr),
    .alm_load_i(alm_load), .alm_tod_i(alm_in_w),
    .per_load_i(per_load), .per_code_i(per_code),
    .en_o(en_w), .arm_o(arm_w), .uen_rise_o(uen_rise_w),
    .alm_o(alm_w), .limit_o(limit_w), .step_o(step_w)
  );

  rtc_evt_catchup #(.CW(CW), .LW(LW)) u_cu (
    .clk(clk), .rst_n(rst_n), .ctr_i(ctr_i), .chan_on_i(chan_on),
    .arm_i(arm_w), .step_i(step_w),
    .cmp_o(cmp_val), .done_o(done_w), .lost_o(lost_w)
  );

  rtc_evt_flags #(.PCW(PCW), .LW(LW)) u_flg (
    .clk(clk), .rst_n(rst_n), .done_i(done_w), .lost_i(lost_w),
    .en_i(en_w), .uen_rise_i(uen_rise_w), .now_i(now_w), .alm_i(alm_w),
    .limit_i(limit_w), .status_o(status), .irq_o(irq)
  );

  // R4
  irq_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[15:8] == 8'd1 && status[7] && status[6:4] != 3'b000 && status[3:0] == 4'b0000));

  // R11
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(chan_on));

endmodule

// File: tb/tb_rtc_evt_gen.sv
module tb_rtc_evt_gen;

  localparam int CLK_NS = 10;
  localparam int NROW   = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctr_i = '0;
  logic [4:0]  now_hr = '0;
  logic [5:0]  now_min = '0, now_sec = '0;
  logic [2:0]  en_set = '0, en_clr = '0;
  logic        alm_load = 1'b0, per_load = 1'b0;
  logic [4:0]  alm_hr = '0;
  logic [5:0]  alm_min = '0, alm_sec = '0;
  logic [3:0]  per_code = '0;
  logic [15:0] status;
  logic        irq, chan_on;
  logic [31:0] cmp_val;

  int total = 0;
  int bad   = 0;

  always #(CLK_NS/2) clk = ~clk;

  rtc_evt_gen dut (
    .clk(clk), .rst_n(rst_n), .ctr_i(ctr_i),
    .now_hr(now_hr), .now_min(now_min), .now_sec(now_sec),
    .en_set(en_set), .en_clr(en_clr),
    .alm_load(alm_load), .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
    .per_load(per_load), .per_code(per_code),
    .status(status), .irq(irq), .chan_on(chan_on), .cmp_val(cmp_val)
  );

  // update+periodic scenario, rate code 5 -> limit 2, step 1024
  localparam logic [31:0] T_CTR [NROW] = '{32'd2030, 32'd3050, 32'd4080, 32'd5100, 32'd9000, 32'd9200, 32'd10220};
  localparam logic [5:0]  T_SEC [NROW] = '{6'd10, 6'd10, 6'd11, 6'd11, 6'd12, 6'd12, 6'd12};
  localparam int          T_NIRQ[NROW] = '{0, 1, 1, 1, 1, 0, 1};
  localparam logic [15:0] T_STAT[NROW] = '{16'h0000, 16'h01C0, 16'h0190, 16'h01C0, 16'h01D0, 16'h0000, 16'h01C0};
  localparam logic [31:0] T_CMP [NROW] = '{32'd3048, 32'd4072, 32'd5096, 32'd6120, 32'd9192, 32'd10216, 32'd11240};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic en_op(input logic [2:0] s, input logic [2:0] c, input logic [31:0] ctr);
    @(negedge clk);
    en_set = s; en_clr = c; ctr_i = ctr;
    @(negedge clk);
    en_set = '0; en_clr = '0;
  endtask

  task automatic per_op(input logic [3:0] code);
    @(negedge clk);
    per_code = code; per_load = 1'b1;
    @(negedge clk);
    per_load = 1'b0;
  endtask

  task automatic svc(input logic [31:0] c, input logic [5:0] s, output int n, output logic [15:0] st);
    @(negedge clk);
    ctr_i = c; now_sec = s;
    n = 0; st = '0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq) begin n++; st = status; end
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++; total++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] st;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 status", 32'(status), 0);
    check("R1 chan_on", 32'(chan_on), 0);
    check("R1 cmp", cmp_val, 0);
    rst_n = 1'b1;

    // R2 clear beats set on the same bit
    en_op(3'b010, 3'b010, 32'd500);
    check("R2 clr wins", 32'(chan_on), 0);

    // R8 rate code 5, then R3 arm at counter+1024
    per_op(4'd5);
    en_op(3'b101, 3'b000, 32'd1000);
    check("R2 chan_on", 32'(chan_on), 1);
    check("R3 arm cmp", cmp_val, 32'd2024);

    // table: R4 R5 R6 R8 R10
    for (int r = 0; r < NROW; r++) begin
      svc(T_CTR[r], T_SEC[r], n, st);
      check($sformatf("R4/R6/R8 row%0d irq count", r), 32'(n), 32'(T_NIRQ[r]));
      if (T_NIRQ[r] != 0) check($sformatf("R5/R10 row%0d status", r), 32'(st), 32'(T_STAT[r]));
      check($sformatf("R4 row%0d cmp", r), cmp_val, T_CMP[r]);
    end

    // R11 all disabled: no service even past comparator
    en_op(3'b000, 3'b111, 32'd11000);
    check("R11 chan off", 32'(chan_on), 0);
    svc(32'd15000, 6'd13, n, st);
    check("R11 no irq", 32'(n), 0);
    check("R11 cmp held", cmp_val, 32'd11240);

    // R7 alarm at 05:30:45
    @(negedge clk);
    alm_hr = 5'd5; alm_min = 6'd30; alm_sec = 6'd45; alm_load = 1'b1;
    now_hr = 5'd5; now_min = 6'd30;
    @(negedge clk);
    alm_load = 1'b0;
    en_op(3'b010, 3'b000, 32'd20000);
    check("R3 rearm cmp", cmp_val, 32'd21024);
    svc(32'd21030, 6'd44, n, st);
    check("R7 no match", 32'(n), 0);
    svc(32'd22060, 6'd45, n, st);
    check("R7 match count", 32'(n), 1);
    check("R7 match status", 32'(st), 32'h01A0);
    now_min = 6'd31;
    svc(32'd23080, 6'd45, n, st);
    check("R7 minute differs", 32'(n), 0);

    // R9 fast rate code 8 -> step 256, flag every service
    en_op(3'b000, 3'b111, 32'd29000);
    per_op(4'd8);
    en_op(3'b100, 3'b000, 32'd30000);
    check("R9 fast step arm", cmp_val, 32'd30256);
    svc(32'd30260, 6'd45, n, st);
    check("R9 first flag", 32'(n), 1);
    check("R9 first status", 32'(st), 32'h01C0);
    check("R9 cmp", cmp_val, 32'd30512);
    svc(32'd30520, 6'd46, n, st);
    check("R9 second flag", 32'(n), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule